// File: doc/BRIEF.md
# Scattered Pilot Phase Detector with Two-Pass Confirmation

This block works out which of four scattered-pilot phase offsets an OFDM symbol carries. Frequency-domain subcarrier samples arrive one per cycle as signed I/Q with their carrier index. The block squares and sums each sample's components and adds the result into one of four candidate scores, chosen by the carrier index. A start-of-symbol pulse closes the symbol, and the largest score names the offset.

The first symbol gives a guess. The block then predicts the next offset (one step on, modulo four) and measures the next symbol to confirm it. If the two agree, the detector locks and then steps its mode output on every later symbol start. If they disagree, it throws the result away and starts over with the symbol that has just begun. While the confirming symbol is being measured, samples at the predicted pilot positions are passed out as write strobes for a channel-estimation pre-fill store. A single pulse then tells that store whether to keep those writes or drop them.

Top module: `sp_pilot_sync`

## Requirements
- R1: After reset, `locked_o`=0, `mode_o`=0, and `commit_o`, `discard_o` and `fill_we_o` are all 0.
- R2: A sample with index i adds I²+Q² to candidate k exactly when i mod 12 = 3k, for k in 0..3. Samples whose index gives a remainder of 1, 2, 4, 5, 7, 8, 10 or 11 change no score.
- R3: When a symbol closes, the candidate with the largest summed score wins. If scores tie, the lowest k wins. A symbol with equal power on every carrier therefore yields 0.
- R4: When the first pass yields k1, the next symbol's predicted offset is (k1+1) mod 4. If the second pass also yields that value, then in the cycle after the closing pulse `commit_o` pulses, `locked_o` rises and `mode_o` = (k1+2) mod 4, the offset of the symbol just starting.
- R5: If the second pass disagrees with the prediction, `discard_o` pulses in the cycle after the closing pulse, and the symbol just starting becomes a new first pass. With a single error, lock arrives at the close of the fourth symbol.
- R6: During the second-pass symbol, every valid sample whose index mod 12 equals 3×prediction appears one cycle later with `fill_we_o`=1 and its index and I/Q on the fill outputs. No fill write occurs at any other time.
- R7: While locked, `mode_o` advances by 1 modulo 4 one cycle after each `sym_start_i`, and it holds otherwise.
- R8: `restart_i` has priority over all other inputs. One cycle later the block is idle, with `locked_o`=0 and `mode_o`=0. If it arrives during the second pass it also pulses `discard_o`.
- R9: A sample presented in the same cycle as `sym_start_i` belongs to the symbol that is starting.
- R10: Before the first `sym_start_i` after reset or restart, samples are ignored and no strobe is produced.
- R11: `commit_o` and `discard_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous return to idle |
| sym_start_i | input | 1 | Pulse marking the first cycle of a symbol |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_idx_i | input | IDX_W | Carrier index of the sample |
| smp_re_i | input | SAMPLE_W | In-phase part, signed |
| smp_im_i | input | SAMPLE_W | Quadrature part, signed |
| mode_o | output | 2 | Offset of the current symbol once locked |
| locked_o | output | 1 | Detection confirmed |
| commit_o | output | 1 | Keep the pre-filled pilots |
| discard_o | output | 1 | Drop the pre-filled pilots |
| fill_we_o | output | 1 | Pre-fill write strobe |
| fill_idx_o | output | IDX_W | Index of the pre-fill write |
| fill_re_o | output | SAMPLE_W | In-phase part of the pre-fill write |
| fill_im_o | output | SAMPLE_W | Quadrature part of the pre-fill write |

## Verification
A wrong score selection or a lost tie rule shows up as a wrong prediction. That becomes visible at the close of the confirming symbol, as a discard where a commit was due or a `mode_o` off by one. A bad prediction register shows up sooner: within one cycle of the first sample at a pilot position in the confirming symbol, as fill writes at the wrong indices. Once locked, a mis-stepped mode counter gives a wrong `mode_o` one cycle after the next symbol start.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS1 = 2'd1,
    ST_PASS2 = 2'd2,
    ST_LOCK  = 2'd3
  } sp_state_e;

  localparam int unsigned NUM_CAND = 4;
  localparam int unsigned GRID     = 12;
endpackage

// File: rtl/sp_carrier_sel.sv
module sp_carrier_sel #(
  parameter int unsigned IDX_W = 13
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o,
  output logic [1:0]       cand_o
);
  logic [3:0] rem;

  assign rem    = 4'(idx_i % IDX_W'(sp_pkg::GRID));
  assign hit_o  = (rem == 4'd0) || (rem == 4'd3) || (rem == 4'd6) || (rem == 4'd9);
  assign cand_o = 2'(rem / 4'd3);
endmodule

// File: rtl/sp_score_bank.sv
module sp_score_bank #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned SCORE_W  = 34
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               clr_i,
  input  logic                               add_i,
  input  logic [1:0]                         cand_i,
  input  logic signed [SAMPLE_W-1:0]         re_i,
  input  logic signed [SAMPLE_W-1:0]         im_i,
  output logic [sp_pkg::NUM_CAND-1:0][SCORE_W-1:0] score_o
);
  localparam int unsigned PW = 2 * SAMPLE_W;

  logic signed [PW-1:0] sq_re, sq_im;
  logic [PW:0]          pwr;

  assign sq_re = re_i * re_i;
  assign sq_im = im_i * im_i;
  assign pwr   = {1'b0, sq_re} + {1'b0, sq_im};

  for (genvar k = 0; k < sp_pkg::NUM_CAND; k++) begin : g_cand
    logic hit;
    assign hit = add_i && (cand_i == 2'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    score_o[k] <= '0;
      else if (clr_i) score_o[k] <= hit ? SCORE_W'(pwr) : '0;
      else if (hit)   score_o[k] <= score_o[k] + SCORE_W'(pwr);
    end
  end
endmodule

// File: rtl/sp_argmax.sv
module sp_argmax #(
  parameter int unsigned SCORE_W = 34
) (
  input  logic [sp_pkg::NUM_CAND-1:0][SCORE_W-1:0] score_i,
  output logic [1:0]                               win_o
);
  logic [SCORE_W-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    win_o = 2'd0;
    best  = score_i[0];
    for (int k = 1; k < sp_pkg::NUM_CAND; k++) begin
      if (score_i[k] > best) begin
        best  = score_i[k];
        win_o = 2'(k);
      end
    end
  end
endmodule

// File: rtl/sp_pilot_sync.sv
module sp_pilot_sync #(
  parameter int unsigned SAMPLE_W     = 12,
  parameter int unsigned IDX_W        = 13,
  parameter int unsigned MAX_CARRIERS = 6817
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       sym_start_i,
  input  logic                       smp_valid_i,
  input  logic [IDX_W-1:0]           smp_idx_i,
  input  logic signed [SAMPLE_W-1:0] smp_re_i,
  input  logic signed [SAMPLE_W-1:0] smp_im_i,
  output logic [1:0]                 mode_o,
  output logic                       locked_o,
  output logic                       commit_o,
  output logic                       discard_o,
  output logic                       fill_we_o,
  output logic [IDX_W-1:0]           fill_idx_o,
  output logic signed [SAMPLE_W-1:0] fill_re_o,
  output logic signed [SAMPLE_W-1:0] fill_im_o
);
  import sp_pkg::*;

  localparam int unsigned PER_CAND = MAX_CARRIERS / GRID + 1;
  localparam int unsigned SCORE_W  = 2 * SAMPLE_W + $clog2(PER_CAND + 1);

  sp_state_e  st_q, st_d;
  logic [1:0] pred_q, pred_d, mode_q, mode_d, win;
  logic       lock_q, lock_d, commit_d, discard_d, fill_we_d;
  logic       hit;
  logic [1:0] cand;
  logic [NUM_CAND-1:0][SCORE_W-1:0] score;

  sp_carrier_sel #(.IDX_W(IDX_W)) u_sel (
    .idx_i (smp_idx_i),
    .hit_o (hit),
    .cand_o(cand)
  );

  sp_score_bank #(.SAMPLE_W(SAMPLE_W), .SCORE_W(SCORE_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sym_start_i && !restart_i),
    .add_i  (smp_valid_i && hit && !restart_i),
    .cand_i (cand),
    .re_i   (smp_re_i),
    .im_i   (smp_im_i),
    .score_o(score)
  );

  sp_argmax #(.SCORE_W(SCORE_W)) u_max (
    .score_i(score),
    .win_o  (win)
  );

  always_comb begin
    st_d      = st_q;
    pred_d    = pred_q;
    mode_d    = mode_q;
    lock_d    = lock_q;
    commit_d  = 1'b0;
    discard_d = 1'b0;
    if (restart_i) begin
      st_d      = ST_IDLE;
      lock_d    = 1'b0;
      mode_d    = 2'd0;
      discard_d = (st_q == ST_PASS2);
    end else if (sym_start_i) begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_PASS1;
        ST_PASS1: begin
          pred_d = win + 2'd1;
          st_d   = ST_PASS2;
        end
        ST_PASS2: begin
          if (win == pred_q) begin
            commit_d = 1'b1;
            lock_d   = 1'b1;
            mode_d   = pred_q + 2'd1;
            st_d     = ST_LOCK;
          end else begin
            discard_d = 1'b1;
            st_d      = ST_PASS1;
          end
        end
        ST_LOCK:  mode_d = mode_q + 2'd1;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  assign fill_we_d = smp_valid_i && !restart_i && (st_d == ST_PASS2) && hit && (cand == pred_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pred_q     <= 2'd0;
      mode_q     <= 2'd0;
      lock_q     <= 1'b0;
      commit_o   <= 1'b0;
      discard_o  <= 1'b0;
      fill_we_o  <= 1'b0;
      fill_idx_o <= '0;
      fill_re_o  <= '0;
      fill_im_o  <= '0;
    end else begin
      st_q      <= st_d;
      pred_q    <= pred_d;
      mode_q    <= mode_d;
      lock_q    <= lock_d;
      commit_o  <= commit_d;
      discard_o <= discard_d;
      fill_we_o <= fill_we_d;
      if (fill_we_d) begin
        fill_idx_o <= smp_idx_i;
        fill_re_o  <= smp_re_i;
        fill_im_o  <= smp_im_i;
      end
    end
  end

  assign mode_o   = mode_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/sp_pilot_sync_chk.sv
module sp_pilot_sync_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic       sym_start_i,
  input logic [1:0] mode_o,
  input logic       locked_o,
  input logic       commit_o,
  input logic       discard_o,
  input logic       fill_we_o
);
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && discard_o));

  p_commit_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  p_lock_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> commit_o);

  p_restart_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!locked_o && mode_o == 2'd0));

  p_mode_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && sym_start_i && !restart_i) |=> (locked_o && mode_o == $past(mode_o) + 2'd1));

  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !sym_start_i && !restart_i) |=> (locked_o && $stable(mode_o)));

  p_no_fill_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_o |-> !locked_o);
endmodule

bind sp_pilot_sync sp_pilot_sync_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .restart_i  (restart_i),
  .sym_start_i(sym_start_i),
  .mode_o     (mode_o),
  .locked_o   (locked_o),
  .commit_o   (commit_o),
  .discard_o  (discard_o),
  .fill_we_o  (fill_we_o)
);

// File: tb/sp_pilot_sync_test.sv
module sp_pilot_sync_test;
  localparam int SW = 12;
  localparam int IW = 13;
  localparam int NC = 96;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_ni, restart_i, sym_start_i, smp_valid_i;
  logic [IW-1:0]        smp_idx_i;
  logic signed [SW-1:0] smp_re_i, smp_im_i;
  logic [1:0]           mode_o;
  logic                 locked_o, commit_o, discard_o, fill_we_o;
  logic [IW-1:0]        fill_idx_o;
  logic signed [SW-1:0] fill_re_o, fill_im_o;

  sp_pilot_sync uut (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart_i), .sym_start_i(sym_start_i),
    .smp_valid_i(smp_valid_i), .smp_idx_i(smp_idx_i), .smp_re_i(smp_re_i), .smp_im_i(smp_im_i),
    .mode_o(mode_o), .locked_o(locked_o), .commit_o(commit_o), .discard_o(discard_o),
    .fill_we_o(fill_we_o), .fill_idx_o(fill_idx_o), .fill_re_o(fill_re_o), .fill_im_o(fill_im_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int st = 0, pred = 0, mode = 0, lk = 0;
  longint sc[4];

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // R3: largest score, lowest index on ties
  function automatic int best_cand();
    int b = 0;
    for (int k = 1; k < 4; k++) if (sc[k] > sc[b]) b = k;
    return b;
  endfunction

  task automatic step(bit v, int re, int im, int idx, bit ss, bit rs);
    int e_c = 0, e_d = 0, e_w = 0;
    @(negedge clk);
    smp_valid_i = v; smp_re_i = SW'(re); smp_im_i = SW'(im);
    smp_idx_i = IW'(idx); sym_start_i = ss; restart_i = rs;
    if (rs) begin
      if (st == 2) e_d = 1;
      st = 0; lk = 0; mode = 0;
    end else begin
      if (ss) begin
        case (st)
          0: st = 1;
          1: begin pred = (best_cand() + 1) % 4; st = 2; end
          2: begin
            if (best_cand() == pred) begin e_c = 1; lk = 1; mode = (pred + 1) % 4; st = 3; end
            else begin e_d = 1; st = 1; end
          end
          default: mode = (mode + 1) % 4;
        endcase
        for (int k = 0; k < 4; k++) sc[k] = 0;
      end
      // R2 / R9: sample joins the symbol that is current after the pulse
      if (v && (idx % 12) % 3 == 0) sc[(idx % 12) / 3] += longint'(re * re + im * im);
      if (v && st == 2 && idx % 12 == 3 * pred) e_w = 1;
    end
    @(posedge clk); #1;
    chk("R4 locked_o", locked_o, lk);
    chk("R7 mode_o", mode_o, mode);
    chk("R4 commit_o", commit_o, e_c);
    chk("R5 discard_o", discard_o, e_d);
    chk("R6 fill_we_o", fill_we_o, e_w);
    chk("R11 strobes exclusive", commit_o && discard_o, 0);
    if (e_w) begin
      chk("R6 fill_idx_o", fill_idx_o, idx);
      chk("R6 fill_re_o", fill_re_o, re);
      chk("R6 fill_im_o", fill_im_o, im);
    end
  endtask

  function automatic int rnd(int a);
    return int'($urandom % (2 * a + 1)) - a;
  endfunction

  // m = -2: equal power everywhere; heavy: big values at off-grid indices
  task automatic send_sym(int m, int boost, int noise, bit heavy);
    for (int idx = 0; idx < NC; idx++) begin
      int r = idx % 12, re, im;
      if (idx > 0 && $urandom % 4 == 0) step(0, 0, 0, 0, 0, 0);
      if (m == -2) begin re = 100; im = 0; end
      else if (r == 3 * m) begin re = boost; im = -(boost / 2); end
      else if (heavy && (r == 1 || r == 2)) begin re = 2000; im = -2000; end
      else begin re = rnd(noise); im = rnd(noise); end
      step(1, re, im, idx, idx == 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    summary();
  end

  initial begin
    int m;
    void'($urandom(32'd7719));
    for (int k = 0; k < 4; k++) sc[k] = 0;
    rst_ni = 0; restart_i = 0; sym_start_i = 0; smp_valid_i = 0;
    smp_idx_i = '0; smp_re_i = '0; smp_im_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk("R1 locked_o", locked_o, 0);
    chk("R1 mode_o", mode_o, 0);
    chk("R1 commit_o", commit_o, 0);
    chk("R1 discard_o", discard_o, 0);
    chk("R1 fill_we_o", fill_we_o, 0);

    // R10: idle samples produce nothing
    for (int i = 0; i < 20; i++) step(1, 2000, 2000, 3 * (i % 4), 0, 0);
    chk("R10 idle no lock", locked_o, 0);

    // clean lock, then R7 stepping
    send_sym(2, 900, 100, 0);
    send_sym(3, 900, 100, 0);
    send_sym(0, 900, 100, 0);
    chk("R4 locked after two symbols", locked_o, 1);
    chk("R4 mode after lock", mode_o, 0);
    send_sym(1, 900, 100, 0);
    send_sym(2, 900, 100, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R8 restart unlock", locked_o, 0);

    // R5: one error, lock on fourth symbol close
    send_sym(1, 900, 100, 0);
    send_sym(0, 900, 100, 0);
    send_sym(1, 900, 100, 0);
    chk("R5 not locked after error", locked_o, 0);
    send_sym(2, 900, 100, 0);
    send_sym(3, 900, 100, 0);
    chk("R5 locked after four symbols", locked_o, 1);
    chk("R5 mode after late lock", mode_o, 3);

    // R8: restart during second pass, and restart with start pulse
    step(0, 0, 0, 0, 0, 1);
    send_sym(0, 900, 100, 0);
    send_sym(1, 900, 100, 0);
    step(1, 900, 0, 3, 1, 1);
    chk("R8 restart over start", locked_o, 0);

    // R3: tie goes to candidate 0, so prediction 1
    send_sym(-2, 0, 0, 0);
    send_sym(1, 900, 100, 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R3 tie lock", locked_o, 1);
    chk("R3 tie mode", mode_o, 2);

    // R2: off-grid energy ignored
    step(0, 0, 0, 0, 0, 1);
    send_sym(2, 600, 50, 1);
    send_sym(3, 600, 50, 1);
    send_sym(0, 600, 50, 1);
    chk("R2 off-grid ignored", locked_o, 1);

    // random run
    m = 0;
    for (int s = 0; s < 40; s++) begin
      if ($urandom % 10 == 0) step(0, 0, 0, 0, 0, 1);
      if ($urandom % 4 == 0) m = int'($urandom % 4);
      else m = (m + 1) % 4;
      send_sym(m, 300 + int'($urandom % 1200), int'($urandom % 300), bit'($urandom % 2));
    end
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule